// File: doc/BRIEF.md
# Register Change Trace Monitor

This block sits beside a processor's retirement stage and produces a compact trace of architectural state. When an operation retires, the block compares the register snapshot bus against its own shadow copies. It then emits one (id, value) record for every register whose value has moved since the previous report. The snapshot bus carries the next and next-next program counters, a condition-code register, an auxiliary multiply/divide register, 32 integer registers and 32 64-bit floating-point entries.

Reports are made once per macro-instruction. A plain instruction reports when it retires. A micro-op sequence reports only at its final micro-op, and the micro-ops before it are dropped without a trace. Records leave through a registered valid/ready port, and each report closes with an end marker. While a scan runs, `busy` stalls the retire input. The processor must hold the snapshot bus steady while `busy` is high.

Top module: `regdelta_tracer`

## Requirements
- R1: A retire with `ret_is_micro`=1 and `ret_is_last`=0 produces no record, leaves `busy` low and leaves every shadow copy unchanged. A retire with `ret_is_micro`=0, or with `ret_is_last`=1, starts a report.
- R2: Every report begins with the next PC (id 0x01), followed by the next-next PC (id 0x02). Both are emitted whatever their values.
- R3: The condition-code register (id 0x03) and the auxiliary register (id 0x04) are emitted, in that order, only when they differ from their shadow copy. An emitted value becomes the new shadow copy.
- R4: Integer register n = slot + 8 × group, where groups 0..3 are global, out, local and in. It is reported under id 0x20+n, in ascending n after id 0x04, and only when it changed.
- R5: Floating-point entry k (the 64-bit value at even register number 2k) is reported under id 0x40+2k, in ascending k after the integer registers, and only when it changed.
- R6: All shadow copies are zero after reset, so the first report emits every nonzero register.
- R7: Every report ends with an end record of id 0xFF and value 0.
- R8: `busy` rises in the cycle after a report starts. It falls in the cycle after the end record is accepted. A retire presented while `busy` is high is ignored.
- R9: A record held with `out_valid`=1 and `out_ready`=0 stays unchanged in id and value until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Retire strobe |
| ret_is_micro | input | 1 | Retiring operation is a micro-op |
| ret_is_last | input | 1 | Retiring micro-op ends its sequence |
| npc | input | W | Next program counter |
| nnpc | input | W | Next-next program counter |
| ccr | input | W | Condition-code register |
| yreg | input | W | Auxiliary multiply/divide register |
| int_bus | input | NUM_INT×W | Integer registers, register n at bits n×W |
| fp_bus | input | NUM_FP×W | Floating-point entries, entry k at bits k×W |
| busy | output | 1 | Scan in progress; retire is stalled |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer accepts record |
| out_id | output | 8 | Record id |
| out_val | output | W | Record value |

## Verification
On every cycle the assertions check the following: the output hold under back-pressure, that an accepted report raises `busy` and a skipped micro-op does not, that the first record of a report is the next PC, that the end record carries zero, that floating-point ids are even, and that `busy` drops after the end record. Whether the right registers appear and the unchanged ones stay silent is visible only in the bench scenarios. These compare whole record streams against a shadow model. They cover the zero-state first report, micro-op sequences whose state changes during dropped micro-ops, and retires ignored while busy.

// File: rtl/regdelta_pkg.sv
package regdelta_pkg;

  localparam logic [7:0] ID_NPC  = 8'h01;
  localparam logic [7:0] ID_NNPC = 8'h02;
  localparam logic [7:0] ID_CCR  = 8'h03;
  localparam logic [7:0] ID_Y    = 8'h04;
  localparam logic [7:0] ID_INT0 = 8'h20;
  localparam logic [7:0] ID_FP0  = 8'h40;
  localparam logic [7:0] ID_END  = 8'hFF;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

  // Slot layout: 0 npc, 1 nnpc, 2 ccr, 3 y, then integers, then fp, then end.
  function automatic logic [7:0] rec_id(int slot, int n_int, int n_fp);
    if (slot < 4)                   return 8'(slot + 1);
    else if (slot < 4 + n_int)      return ID_INT0 + 8'(slot - 4);
    else if (slot < 4 + n_int + n_fp) return ID_FP0 + 8'(2 * (slot - 4 - n_int));
    else                            return ID_END;
  endfunction

endpackage

// File: rtl/regdelta_shadow.sv
module regdelta_shadow #(
  parameter int W     = 64,
  parameter int DEPTH = 66,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] seen;

  // Storage has no reset; a per-entry flag makes never-written entries read zero.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (wr_en) seen[wr_addr] <= 1'b1;
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_addr) < DEPTH && seen[rd_addr]) rd_data = mem[rd_addr];
  end
endmodule

// File: rtl/regdelta_scan.sv
module regdelta_scan
  import regdelta_pkg::*;
#(
  parameter int W       = 64,
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  localparam int NTRACK = 2 + NUM_INT + NUM_FP,
  localparam int NSLOT  = 2 + NTRACK,
  localparam int SW     = $clog2(NSLOT + 1),
  localparam int AW     = $clog2(NTRACK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  slot_val,
  input  logic [W-1:0]  shadow_val,
  output logic [SW-1:0] slot,
  output logic          shadow_we,
  output logic [AW-1:0] shadow_addr,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_id,
  output logic [W-1:0]  out_val
);
  scan_st_e state;
  logic can_load, is_end, is_tracked, changed, emit;

  always_comb begin
    can_load    = !out_valid || out_ready;
    is_end      = (32'(slot) == NSLOT);
    is_tracked  = (slot >= SW'(2)) && !is_end;
    changed     = (slot_val != shadow_val);
    emit        = is_end || !is_tracked || changed;
    shadow_we   = (state == ST_SCAN) && can_load && is_tracked && changed;
    shadow_addr = AW'(slot - SW'(2));
    busy        = (state == ST_SCAN) || out_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
      out_val   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_SCAN;
          slot  <= '0;
        end
        ST_SCAN: if (can_load) begin
          if (emit) begin
            out_valid <= 1'b1;
            out_id    <= rec_id(int'(slot), NUM_INT, NUM_FP);
            out_val   <= is_end ? '0 : slot_val;
          end
          if (is_end) state <= ST_IDLE;
          else        slot  <= slot + SW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regdelta_tracer.sv
module regdelta_tracer #(
  parameter int W       = 64,
  parameter int NUM_INT = 32,
  parameter int NUM_FP  = 32,
  localparam int NTRACK = 2 + NUM_INT + NUM_FP,
  localparam int NSLOT  = 2 + NTRACK,
  localparam int SW     = $clog2(NSLOT + 1),
  localparam int AW     = $clog2(NTRACK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ret_valid,
  input  logic                 ret_is_micro,
  input  logic                 ret_is_last,
  input  logic [W-1:0]         npc,
  input  logic [W-1:0]         nnpc,
  input  logic [W-1:0]         ccr,
  input  logic [W-1:0]         yreg,
  input  logic [NUM_INT*W-1:0] int_bus,
  input  logic [NUM_FP*W-1:0]  fp_bus,
  output logic                 busy,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_id,
  output logic [W-1:0]         out_val
);
  logic [W-1:0]  vals [NSLOT];
  logic [W-1:0]  slot_val, shadow_val;
  logic [SW-1:0] slot;
  logic          shadow_we, start;
  logic [AW-1:0] shadow_addr;

  assign vals[0] = npc;
  assign vals[1] = nnpc;
  assign vals[2] = ccr;
  assign vals[3] = yreg;
  for (genvar i = 0; i < NUM_INT; i++) begin : g_int
    assign vals[4+i] = int_bus[i*W +: W];
  end
  for (genvar k = 0; k < NUM_FP; k++) begin : g_fp
    assign vals[4+NUM_INT+k] = fp_bus[k*W +: W];
  end

  always_comb begin
    slot_val = '0;
    for (int s = 0; s < NSLOT; s++) if (32'(slot) == s) slot_val = vals[s];
  end

  assign start = ret_valid && !busy && (!ret_is_micro || ret_is_last);

  regdelta_shadow #(.W(W), .DEPTH(NTRACK)) shadow_i (
    .clk(clk), .rst(rst), .wr_en(shadow_we), .wr_addr(shadow_addr),
    .wr_data(slot_val), .rd_addr(shadow_addr), .rd_data(shadow_val)
  );

  regdelta_scan #(.W(W), .NUM_INT(NUM_INT), .NUM_FP(NUM_FP)) scan_i (
    .clk(clk), .rst(rst), .start(start), .slot_val(slot_val),
    .shadow_val(shadow_val), .slot(slot), .shadow_we(shadow_we),
    .shadow_addr(shadow_addr), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_id(out_id), .out_val(out_val)
  );
endmodule

// File: rtl/regdelta_checker.sv
module regdelta_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         ret_valid,
  input logic         ret_is_micro,
  input logic         ret_is_last,
  input logic         busy,
  input logic         out_valid,
  input logic         out_ready,
  input logic [7:0]   out_id,
  input logic [W-1:0] out_val
);
  logic first_pending;

  always_ff @(posedge clk) begin
    if (rst) first_pending <= 1'b0;
    else if (ret_valid && !busy && (!ret_is_micro || ret_is_last)) first_pending <= 1'b1;
    else if (out_valid && out_ready) first_pending <= 1'b0;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_val));

  assert_start_R8: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !busy && (!ret_is_micro || ret_is_last) |=> busy);

  assert_skip_R1: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !busy && ret_is_micro && !ret_is_last |=> !busy && !out_valid);

  assert_first_npc_R2: assert property (@(posedge clk) disable iff (rst)
    first_pending && out_valid |-> out_id == 8'h01);

  assert_end_zero_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_id == 8'hFF |-> out_val == '0);

  assert_fp_even_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_id[7:6] == 2'b01 |-> !out_id[0]);

  assert_end_release_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_id == 8'hFF |=> !busy);
endmodule

bind regdelta_tracer regdelta_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_is_micro(ret_is_micro),
  .ret_is_last(ret_is_last), .busy(busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_id(out_id), .out_val(out_val)
);

// File: tb/regdelta_tracer_tb.sv
module regdelta_tracer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int NI = 32;
  localparam int NF = 32;

  logic clk = 0, rst = 1;
  logic ret_valid = 0, ret_is_micro = 0, ret_is_last = 0, out_ready = 0;
  logic [W-1:0] npc = 0, nnpc = 0, ccr = 0, yreg = 0;
  logic [W-1:0] s_int [NI];
  logic [W-1:0] s_fp [NF];
  logic [NI*W-1:0] int_bus;
  logic [NF*W-1:0] fp_bus;
  logic busy, out_valid;
  logic [7:0] out_id;
  logic [W-1:0] out_val;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_ccr = 0, m_y = 0;
  logic [W-1:0] m_int [NI];
  logic [W-1:0] m_fp [NF];
  logic [7:0]   e_id [80];
  logic [W-1:0] e_val [80];
  int e_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < NI; i++) int_bus[i*W +: W] = s_int[i];
  always_comb for (int k = 0; k < NF; k++) fp_bus[k*W +: W] = s_fp[k];

  regdelta_tracer #(.W(W), .NUM_INT(NI), .NUM_FP(NF)) dut_i (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_is_micro(ret_is_micro),
    .ret_is_last(ret_is_last), .npc(npc), .nnpc(nnpc), .ccr(ccr), .yreg(yreg),
    .int_bus(int_bus), .fp_bus(fp_bus), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_id(out_id), .out_val(out_val)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void push(logic [7:0] id, logic [W-1:0] v);
    e_id[e_n] = id; e_val[e_n] = v; e_n++;
  endfunction

  // Expected stream from the requirements; updates the bench shadow model.
  function automatic void build_expected();
    e_n = 0;
    push(8'h01, npc); push(8'h02, nnpc);                    // R2
    if (ccr != m_ccr) begin push(8'h03, ccr); m_ccr = ccr; end // R3
    if (yreg != m_y) begin push(8'h04, yreg); m_y = yreg; end
    for (int n = 0; n < NI; n++)                             // R4
      if (s_int[n] != m_int[n]) begin push(8'h20 + 8'(n), s_int[n]); m_int[n] = s_int[n]; end
    for (int k = 0; k < NF; k++)                             // R5
      if (s_fp[k] != m_fp[k]) begin push(8'h40 + 8'(2*k), s_fp[k]); m_fp[k] = s_fp[k]; end
    push(8'hFF, '0);                                         // R7
  endfunction

  function automatic logic [W-1:0] rval();
    return {$urandom(), $urandom()};
  endfunction

  task automatic mutate(int pct);
    if ($urandom_range(99) < pct) npc = rval();
    if ($urandom_range(99) < pct) nnpc = rval();
    if ($urandom_range(99) < pct) ccr = rval();
    if ($urandom_range(99) < pct) yreg = ($urandom_range(3) == 0) ? '0 : rval();
    for (int i = 0; i < NI; i++) if ($urandom_range(99) < pct) s_int[i] = rval();
    for (int k = 0; k < NF; k++) if ($urandom_range(99) < pct) s_fp[k] = rval();
  endtask

  task automatic retire(logic micro, logic last);
    @(negedge clk);
    ret_valid = 1; ret_is_micro = micro; ret_is_last = last;
    @(negedge clk);
    ret_valid = 0; ret_is_micro = 0; ret_is_last = 0;
  endtask

  // Collect one report with random back-pressure and compare it record by record.
  task automatic collect(string req, int ready_pct, bit poke_retire);
    int got = 0, guard = 0;
    bit done = 0, held = 0;
    logic [7:0] h_id; logic [W-1:0] h_val;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (held) begin
        check("R9 hold valid", W'(out_valid), W'(1));
        check("R9 hold id", W'(out_id), W'(h_id));
        check("R9 hold value", out_val, h_val);
      end
      if (poke_retire && guard == 5) ret_valid = 1; else ret_valid = 0;
      out_ready = ($urandom_range(99) < ready_pct);
      held = out_valid && !out_ready; h_id = out_id; h_val = out_val;
      if (out_valid && out_ready) begin
        if (got < e_n) begin
          check({req, " id"}, W'(out_id), W'(e_id[got]));
          check({req, " value"}, out_val, e_val[got]);
        end
        got++;
        if (out_id == 8'hFF) done = 1;
      end
    end
    ret_valid = 0;
    check({req, " record count"}, W'(got), W'(e_n));
    if (!done) check("R8 report completes", 0, 1);
    @(negedge clk); out_ready = 0;
    check("R8 busy released", W'(busy), W'(0));
  endtask

  task automatic quiet_window(string req, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check({req, " no record"}, W'(out_valid), W'(0));
      check({req, " not busy"}, W'(busy), W'(0));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NI; i++) begin s_int[i] = 0; m_int[i] = 0; end
    for (int k = 0; k < NF; k++) begin s_fp[k] = 0; m_fp[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R6 reset out_valid", W'(out_valid), W'(0));
    check("R6 reset busy", W'(busy), W'(0));

    // R6: first report after reset emits only nonzero registers.
    npc = 64'h1000; nnpc = 64'h1004; ccr = 64'h5;
    s_int[0] = 64'hAA; s_int[9] = 64'h1; s_int[31] = 64'hFFFF_0000_0000_0001; s_fp[0] = 64'h7; s_fp[31] = 64'h3;
    build_expected(); retire(0, 0); collect("R6 first report", 100, 0);

    // R2/R7: nothing changed -> only the two PCs and the end record.
    build_expected(); retire(0, 0); collect("R2 unchanged report", 60, 0);

    // R1: non-final micro-ops change state but produce nothing.
    s_int[5] = 64'h55; ccr = 64'h9;
    retire(1, 0); quiet_window("R1 mid micro-op", 4);
    s_fp[4] = 64'h44;
    retire(1, 0); quiet_window("R1 mid micro-op", 4);
    // Final micro-op reports everything changed since the last report.
    build_expected(); retire(1, 1); collect("R1 final micro-op", 70, 0);

    // R3: Y changes back to zero against a nonzero shadow.
    yreg = 64'h12; build_expected(); retire(0, 0); collect("R3 y set", 100, 0);
    yreg = 64'h0;  build_expected(); retire(0, 0); collect("R3 y cleared", 100, 0);

    // R8: a retire poked while busy is ignored.
    s_int[17] = 64'h17; build_expected(); retire(0, 0); collect("R8 busy report", 50, 1);
    quiet_window("R8 ignored retire", 6);

    // Random reports with mixed plain, micro and back-pressure.
    for (int r = 0; r < 25; r++) begin
      int kind = $urandom_range(2);
      if (kind == 2) begin
        mutate(20); retire(1, 0); quiet_window("R1 random mid micro-op", 2);
      end
      mutate($urandom_range(40));
      build_expected();
      retire(kind != 0, kind != 0);
      collect("R4 R5 random report", 30 + $urandom_range(70), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule